// File: doc/BRIEF.md
# IDE DMA Transfer Progress Tracker

This block follows a disk or optical-drive DMA command as it moves through a series of chunks. A descriptor-driven DMA engine hands it one chunk length at a time. For each chunk it keeps the medium position, the work still left and the DMA address up to date. It tells the engine which medium sector the next chunk starts at. It also reports command completion and errors, raises the drive interrupt, and signals end-of-DMA. Storage access and scatter-gather data movement are outside this block.

Two address domains share one datapath:

- **Disk commands** (read, write, trim) count 512-byte sectors. Each chunk is rounded up to whole sectors.
- **Optical (packet) commands** count bytes. They hold a 2048-byte block number plus an 11-bit byte offset inside that block. The carry out of the offset moves the block number on. The next chunk's 512-byte sector is rebuilt from block and offset.

A transfer is opened with `start`. Each `step` then reports that the previous chunk has finished and offers the next chunk length. A length of zero ends the DMA.

Top module: `ide_dma_progress`

## Requirements
- R1: After a synchronous reset, `busy`, `launch`, `dma_end`, `irq`, `atapi_ok`, both error flags and `status` are all zero.
- R2: `start` loads position, remaining count and DMA address, and clears the pending chunk size. The first `step` that follows therefore leaves position and remaining count unchanged.
- R3: A `step` with nonzero `next_len` and no error does four things one cycle later:
  - pulses `launch`;
  - presents `launch_len` equal to `next_len`;
  - advances `dma_addr` by `next_len`;
  - makes `next_len` the pending size that the following step accounts.
- R4: For a disk transfer, each step accounts the pending size P. The sector address grows by (P+511)>>9 and `left_sectors` shrinks by the same amount. `launch_sector` equals the updated sector address.
- R5: For a disk transfer, when `left_sectors` reaches zero after accounting, `status` becomes 2'b11 and `irq` is set. In `status`, bit 1 means ready and bit 0 means seek complete.
- R6: For an optical transfer, each step accounts the pending size P in three parts:
  - `left_bytes` (signed) decreases by P;
  - the sum offset+P adds sum>>11 to the block number;
  - `cur_offset` keeps the low 11 bits of that sum.
- R7: For an optical transfer, `launch_sector` equals (block<<2) + (offset>>9), taken from the updated block and offset.
- R8: For an optical transfer, when `left_bytes` is zero or negative after accounting, `atapi_ok` pulses for one cycle and `irq` is set.
- R9: A `step` with `next_len` zero and no error pulses `dma_end` and clears `busy`, with no `launch`.
- R10: A `step` with `step_err` high does five things:
  - pulses `dma_end`;
  - clears `busy`;
  - sets `irq`;
  - sets `err_dma` for a disk transfer or `err_io` for an optical one;
  - leaves the position unchanged.
- R11: `step` while `busy` is low is ignored. There is no `launch` and no `dma_end`, and `dma_addr`, `cur_lba` and `cur_offset` are unchanged.
- R12: Starting a disk transfer sets `cur_offset` to zero, whatever `start_offset` is. Starting an optical transfer loads `start_offset`.
- R13: `launch_cmd` carries the command latched at `start`. The encoding is 2'b00 read, 2'b01 write, 2'b10 trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Open a new transfer |
| start_atapi | input | 1 | 1 = optical packet transfer, 0 = disk |
| start_cmd | input | 2 | Disk command: 00 read, 01 write, 10 trim |
| start_lba | input | SECT_W | Initial sector (disk) or 2048-byte block (optical) |
| start_count | input | CNT_W | Sectors to transfer (disk) |
| start_bytes | input | BYTE_W | Packet bytes to transfer (optical, signed) |
| start_offset | input | 11 | Initial byte offset in block (optical) |
| start_addr | input | ADDR_W | Initial DMA memory address |
| step | input | 1 | Chunk completed / next chunk offered |
| step_err | input | 1 | Completed chunk failed |
| next_len | input | LEN_W | Byte length of next chunk, 0 = no more |
| busy | output | 1 | Transfer open |
| launch | output | 1 | One-cycle pulse: issue next chunk |
| launch_sector | output | SECT_W | 512-byte sector for the next chunk |
| launch_len | output | LEN_W | Byte length of the launched chunk |
| launch_cmd | output | 2 | Command of the launched chunk |
| dma_addr | output | ADDR_W | Current DMA memory address |
| dma_end | output | 1 | One-cycle pulse: DMA finished |
| irq | output | 1 | Drive interrupt, cleared by start |
| status | output | 2 | Bit 1 ready, bit 0 seek complete |
| atapi_ok | output | 1 | One-cycle pulse: packet command succeeded |
| err_dma | output | 1 | Disk chunk error flag |
| err_io | output | 1 | Optical chunk error flag |
| cur_lba | output | SECT_W | Current sector (disk) or block (optical) |
| cur_offset | output | 11 | Current byte offset within block |
| left_sectors | output | CNT_W | Disk sectors remaining |
| left_bytes | output | BYTE_W | Packet bytes remaining (signed) |

## Verification
The bench sweeps chunk lengths just below, on and just above the 512-byte and 2048-byte boundaries, and starts optical transfers at offsets that force carries into the block number. A design that truncates instead of rounding up would give sector addresses one short for partial chunks. A design that drops the offset carry would repeat or skip blocks and give wrong launch sectors. It also checks three other corner cases:

- **First step after start:** accounting on this step would move the position before any data had been transferred.
- **Packet count overshoot:** a completion test written as equality instead of "zero or below" would miss a count that goes negative.
- **Error and idle steps:** these must end the DMA without touching the position, and a stray step while idle must change nothing.

// File: rtl/ide_prog_pkg.sv
package ide_prog_pkg;
  localparam int SECT_SHIFT = 9;   // 512-byte sector
  localparam int BLK_SHIFT  = 11;  // 2048-byte optical block
  localparam int OFF_W      = BLK_SHIFT;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_TRIM  = 2'b10
  } ide_cmd_e;
endpackage

// File: rtl/ide_disk_step.sv
module ide_disk_step #(
  parameter int SECT_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic [SECT_W-1:0] sector,
  input  logic [CNT_W-1:0]  count,
  input  logic [LEN_W-1:0]  pend,
  output logic [SECT_W-1:0] nxt_sector,
  output logic [CNT_W-1:0]  nxt_count,
  output logic              done
);
  import ide_prog_pkg::*;
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] rounded;
  logic [SUM_W-1:0] nsec;

  // round pending bytes up to whole sectors
  assign rounded    = SUM_W'(pend) + SUM_W'((1 << SECT_SHIFT) - 1);
  assign nsec       = rounded >> SECT_SHIFT;
  assign nxt_sector = sector + SECT_W'(nsec);
  assign nxt_count  = count - CNT_W'(nsec);
  assign done       = (nxt_count == '0);
endmodule

// File: rtl/ide_atapi_step.sv
module ide_atapi_step #(
  parameter int SECT_W = 32,
  parameter int BYTE_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic [SECT_W-1:0]        blk,
  input  logic [10:0]              off,
  input  logic signed [BYTE_W-1:0] bytes,
  input  logic [LEN_W-1:0]         pend,
  output logic [SECT_W-1:0]        nxt_blk,
  output logic [10:0]              nxt_off,
  output logic signed [BYTE_W-1:0] nxt_bytes,
  output logic                     ok,
  output logic [SECT_W-1:0]        lsect
);
  import ide_prog_pkg::*;
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0]        pos_sum;
  logic signed [BYTE_W-1:0] pend_s;

  assign pos_sum   = SUM_W'(off) + SUM_W'(pend);
  assign nxt_blk   = blk + SECT_W'(pos_sum >> BLK_SHIFT);
  assign nxt_off   = pos_sum[OFF_W-1:0];
  assign pend_s    = BYTE_W'(pend);
  assign nxt_bytes = bytes - pend_s;
  assign ok        = (nxt_bytes <= 0);
  // convert block + offset back to a 512-byte sector
  assign lsect     = (nxt_blk << 2) + SECT_W'(nxt_off[10:9]);
endmodule

// File: rtl/ide_dma_progress.sv
module ide_dma_progress #(
  parameter int SECT_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 24,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_atapi,
  input  logic [1:0]        start_cmd,
  input  logic [SECT_W-1:0] start_lba,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [BYTE_W-1:0] start_bytes,
  input  logic [10:0]       start_offset,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              step,
  input  logic              step_err,
  input  logic [LEN_W-1:0]  next_len,
  output logic              busy,
  output logic              launch,
  output logic [SECT_W-1:0] launch_sector,
  output logic [LEN_W-1:0]  launch_len,
  output logic [1:0]        launch_cmd,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dma_end,
  output logic              irq,
  output logic [1:0]        status,
  output logic              atapi_ok,
  output logic              err_dma,
  output logic              err_io,
  output logic [SECT_W-1:0] cur_lba,
  output logic [10:0]       cur_offset,
  output logic [CNT_W-1:0]  left_sectors,
  output logic [BYTE_W-1:0] left_bytes
);
  import ide_prog_pkg::*;
  localparam int POS_W = SECT_W + OFF_W;

  logic              busy_q, atapi_q, launch_q, dma_end_q, irq_q, ok_q;
  logic              err_dma_q, err_io_q;
  ide_cmd_e          cmd_q, launch_cmd_q;
  logic [1:0]        status_q;
  logic [SECT_W-1:0] lba_q, launch_sector_q;
  logic [CNT_W-1:0]  cnt_q;
  logic signed [BYTE_W-1:0] bytes_q;
  logic [10:0]       off_q;
  logic [LEN_W-1:0]  pend_q, launch_len_q;
  logic [ADDR_W-1:0] dma_addr_q;

  logic [SECT_W-1:0] d_sector, a_blk, a_lsect;
  logic [CNT_W-1:0]  d_count;
  logic              d_done, a_ok;
  logic [10:0]       a_off;
  logic signed [BYTE_W-1:0] a_bytes;
  logic              take;

  ide_disk_step #(.SECT_W(SECT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_disk (
    .sector(lba_q), .count(cnt_q), .pend(pend_q),
    .nxt_sector(d_sector), .nxt_count(d_count), .done(d_done)
  );

  ide_atapi_step #(.SECT_W(SECT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_atapi (
    .blk(lba_q), .off(off_q), .bytes(bytes_q), .pend(pend_q),
    .nxt_blk(a_blk), .nxt_off(a_off), .nxt_bytes(a_bytes), .ok(a_ok),
    .lsect(a_lsect)
  );

  assign take = busy_q && step && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q          <= 1'b0;
      atapi_q         <= 1'b0;
      launch_q        <= 1'b0;
      dma_end_q       <= 1'b0;
      irq_q           <= 1'b0;
      ok_q            <= 1'b0;
      err_dma_q       <= 1'b0;
      err_io_q        <= 1'b0;
      cmd_q           <= CMD_READ;
      launch_cmd_q    <= CMD_READ;
      status_q        <= 2'b00;
      lba_q           <= '0;
      launch_sector_q <= '0;
      cnt_q           <= '0;
      bytes_q         <= '0;
      off_q           <= '0;
      pend_q          <= '0;
      launch_len_q    <= '0;
      dma_addr_q      <= '0;
    end else begin
      launch_q  <= 1'b0;
      dma_end_q <= 1'b0;
      ok_q      <= 1'b0;
      if (start) begin
        busy_q     <= 1'b1;
        atapi_q    <= start_atapi;
        cmd_q      <= ide_cmd_e'(start_cmd);
        lba_q      <= start_lba;
        cnt_q      <= start_count;
        bytes_q    <= start_bytes;
        off_q      <= start_atapi ? start_offset : '0;
        pend_q     <= '0;
        dma_addr_q <= start_addr;
        irq_q      <= 1'b0;
        status_q   <= 2'b00;
        err_dma_q  <= 1'b0;
        err_io_q   <= 1'b0;
      end else if (take) begin
        if (step_err) begin
          busy_q    <= 1'b0;
          dma_end_q <= 1'b1;
          irq_q     <= 1'b1;
          pend_q    <= '0;
          if (atapi_q) err_io_q  <= 1'b1;
          else         err_dma_q <= 1'b1;
        end else begin
          if (atapi_q) begin
            lba_q   <= a_blk;
            off_q   <= a_off;
            bytes_q <= a_bytes;
            if (a_ok) begin
              ok_q  <= 1'b1;
              irq_q <= 1'b1;
            end
          end else begin
            lba_q <= d_sector;
            cnt_q <= d_count;
            if (d_done) begin
              status_q <= 2'b11;
              irq_q    <= 1'b1;
            end
          end
          if (next_len == '0) begin
            busy_q    <= 1'b0;
            dma_end_q <= 1'b1;
            pend_q    <= '0;
          end else begin
            pend_q          <= next_len;
            dma_addr_q      <= dma_addr_q + ADDR_W'(next_len);
            launch_q        <= 1'b1;
            launch_len_q    <= next_len;
            launch_sector_q <= atapi_q ? a_lsect : d_sector;
            launch_cmd_q    <= cmd_q;
          end
        end
      end
    end
  end

  assign busy          = busy_q;
  assign launch        = launch_q;
  assign launch_sector = launch_sector_q;
  assign launch_len    = launch_len_q;
  assign launch_cmd    = launch_cmd_q;
  assign dma_addr      = dma_addr_q;
  assign dma_end       = dma_end_q;
  assign irq           = irq_q;
  assign status        = status_q;
  assign atapi_ok      = ok_q;
  assign err_dma       = err_dma_q;
  assign err_io        = err_io_q;
  assign cur_lba       = lba_q;
  assign cur_offset    = off_q;
  assign left_sectors  = cnt_q;
  assign left_bytes    = bytes_q;

  assert_launch_len_R3: assert property (@(posedge clk) disable iff (rst)
    launch_q |-> (launch_len_q != '0));

  assert_addr_adv_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !step_err && next_len != '0) |=>
      (dma_addr_q == $past(dma_addr_q) + ADDR_W'($past(next_len))));

  assert_disk_adv_R4: assert property (@(posedge clk) disable iff (rst)
    (take && !atapi_q && !step_err) |=>
      ((lba_q - $past(lba_q)) ==
       SECT_W'(((LEN_W+1)'($past(pend_q)) + (LEN_W+1)'(511)) >> 9)));

  assert_atapi_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (take && atapi_q && !step_err) |=>
      ({lba_q, off_q} == {$past(lba_q), $past(off_q)} + POS_W'($past(pend_q))));

  assert_done_irq_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[1]) |-> irq_q);

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (rst)
    dma_end_q |-> (!busy_q && !launch_q));

  assert_err_end_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_dma_q) || $rose(err_io_q)) |-> dma_end_q);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start) |=> (!launch_q && $stable(dma_addr_q) && $stable(lba_q)));
endmodule

// File: tb/tb_ide_dma_progress.sv
module tb_ide_dma_progress;
  localparam int SECT_W = 32, CNT_W = 16, BYTE_W = 24, LEN_W = 16, ADDR_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, start_atapi = 0, step = 0, step_err = 0;
  logic [1:0] start_cmd = 0;
  logic [SECT_W-1:0] start_lba = 0;
  logic [CNT_W-1:0] start_count = 0;
  logic [BYTE_W-1:0] start_bytes = 0;
  logic [10:0] start_offset = 0;
  logic [ADDR_W-1:0] start_addr = 0;
  logic [LEN_W-1:0] next_len = 0;
  logic busy, launch, dma_end, irq, atapi_ok, err_dma, err_io;
  logic [SECT_W-1:0] launch_sector, cur_lba;
  logic [LEN_W-1:0] launch_len;
  logic [1:0] launch_cmd, status;
  logic [ADDR_W-1:0] dma_addr;
  logic [10:0] cur_offset;
  logic [CNT_W-1:0] left_sectors;
  logic [BYTE_W-1:0] left_bytes;

  int checks = 0, errors = 0;

  // model state
  bit e_busy, e_at, e_irq, e_ed, e_ei;
  longint e_lba, e_cnt, e_bytes, e_off, e_pend, e_addr;
  int e_cmd, e_stat;

  always #10 clk = ~clk;

  ide_dma_progress dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " busy"}, busy, e_busy);
    chk({tag, " irq"}, irq, e_irq);
    chk({tag, " status"}, status, e_stat);
    chk({tag, " err_dma"}, err_dma, e_ed);
    chk({tag, " err_io"}, err_io, e_ei);
    chk({tag, " dma_addr"}, dma_addr, e_addr);
    chk({tag, " cur_lba"}, cur_lba, e_lba);
    chk({tag, " cur_offset"}, cur_offset, e_off);
    if (e_at) chk({tag, " left_bytes"}, longint'($signed(left_bytes)), e_bytes);
    else      chk({tag, " left_sectors"}, left_sectors, e_cnt);
  endtask

  task automatic do_start(bit at, int cmd, longint lba, longint cnt,
                          longint bytes, longint off, longint addr);
    @(negedge clk);
    start = 1; start_atapi = at; start_cmd = cmd[1:0];
    start_lba = lba[SECT_W-1:0]; start_count = cnt[CNT_W-1:0];
    start_bytes = bytes[BYTE_W-1:0]; start_offset = off[10:0];
    start_addr = addr[ADDR_W-1:0];
    @(negedge clk);
    start = 0;
    e_busy = 1; e_at = at; e_cmd = cmd; e_lba = lba; e_cnt = cnt;
    e_bytes = bytes; e_off = at ? off : 0; e_pend = 0; e_addr = addr;
    e_irq = 0; e_stat = 0; e_ed = 0; e_ei = 0;
    chk("R12 start offset", cur_offset, e_off);
    chk_state("R2 start");
  endtask

  task automatic do_step(bit err, longint len, string tag);
    bit x_launch = 0, x_end = 0, x_ok = 0;
    longint x_sect = 0, n;
    @(negedge clk);
    step = 1; step_err = err; next_len = len[LEN_W-1:0];
    @(negedge clk);
    step = 0; step_err = 0;
    if (e_busy) begin
      if (err) begin
        x_end = 1; e_busy = 0; e_irq = 1; e_pend = 0;
        if (e_at) e_ei = 1; else e_ed = 1;
      end else begin
        if (!e_at) begin
          n = (e_pend + 511) >> 9;
          e_lba += n; e_cnt -= n;
          if (e_cnt == 0) begin e_stat = 3; e_irq = 1; end
        end else begin
          e_off += e_pend; e_lba += e_off >> 11; e_off &= 2047;
          e_bytes -= e_pend;
          if (e_bytes <= 0) begin x_ok = 1; e_irq = 1; end
        end
        if (len == 0) begin
          x_end = 1; e_busy = 0; e_pend = 0;
        end else begin
          x_launch = 1; e_pend = len; e_addr += len;
          x_sect = e_at ? (e_lba * 4 + (e_off >> 9)) : e_lba;
        end
      end
    end
    chk({tag, " launch"}, launch, x_launch);
    chk({tag, " dma_end"}, dma_end, x_end);
    chk({tag, " atapi_ok"}, atapi_ok, x_ok);
    if (x_launch) begin
      chk({tag, " launch_sector"}, launch_sector, x_sect);
      chk({tag, " launch_len"}, launch_len, len);
      chk({tag, " launch_cmd"}, launch_cmd, e_cmd);
    end
    chk_state(tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);  chk("R1 launch", launch, 0);
    chk("R1 dma_end", dma_end, 0); chk("R1 irq", irq, 0);
    chk("R1 atapi_ok", atapi_ok, 0); chk("R1 err", {err_dma, err_io}, 0);
    chk("R1 status", status, 0);

    // R11 step while idle
    do_step(0, 700, "R11 idle");
    do_step(1, 0, "R11 idle err");

    // R2 first step performs no accounting; R12 disk offset forced to zero
    do_start(0, 0, 50, 20, 0, 1234, 32'h1000);
    do_step(0, 1000, "R2 first");
    chk("R2 lba unchanged", cur_lba, 50);
    do_step(0, 0, "R9 end");

    // R4/R3/R13 disk sweep across sector boundaries, all command types
    for (int i = 0; i < 30; i++) begin
      longint l;
      l = (i < 6) ? ((i % 3) + 511 + 1536 * (i / 3)) : (longint'(i) * 211 + 1);
      do_start(0, i % 3, 1000 + i, 300, 0, 77, 32'h2000 + i * 16);
      do_step(0, l, "R3 launch");
      do_step(0, l, "R4 disk acct");
      do_step(0, l + 1, "R4 disk acct2");
      do_step(0, 0, "R9 disk end");
    end

    // R5 count reaches zero
    do_start(0, 1, 400, 3, 0, 0, 32'h8000);
    do_step(0, 1024, "R5 a");
    do_step(0, 300, "R5 b");
    do_step(0, 0, "R5 done");
    chk("R5 status ready+seek", status, 3);

    // R6/R7/R8 optical sweep over offsets and lengths
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 12; i++) begin
        longint l, off;
        off = (o == 0) ? 0 : (o == 1) ? 100 : (o == 2) ? 1535 : 2047;
        l = (i < 4) ? (2047 + i) : (longint'(i) * 389 + 1);
        do_start(1, 0, 20 + i, 0, 3 * l - 5, off, 32'h4000);
        do_step(0, l, "R7 launch");
        do_step(0, l, "R6 acct");
        do_step(0, l, "R6 acct2");
        do_step(0, l, "R8 overshoot");
        do_step(0, 0, "R9 atapi end");
      end
    end

    // R8 exact-zero completion
    do_start(1, 0, 9, 0, 4096, 0, 0);
    do_step(0, 2048, "R8 a");
    do_step(0, 2048, "R8 b");
    do_step(0, 0, "R8 zero");

    // R10 errors
    do_start(0, 2, 70, 10, 0, 0, 32'h100);
    do_step(0, 512, "R10 pre");
    do_step(1, 512, "R10 disk err");
    chk("R10 lba kept", cur_lba, 70);
    do_start(1, 0, 5, 0, 9000, 300, 32'h200);
    do_step(0, 900, "R10 pre2");
    do_step(1, 900, "R10 atapi err");
    do_step(0, 500, "R11 after err");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule